// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional

This block sits beside one core and provides the hardware half of a load-reserved / store-conditional pair. A reserving load reads a word from a small internal memory model and records the cache line that holds it as reserved. A later conditional store succeeds only if that reservation is still intact. It then writes memory and reports success. Otherwise it writes nothing and reports failure. Software builds compare-and-swap and other atomic sequences from this pair. It does one reserving load, compares the value itself, and then issues one conditional store, retrying on failure.

The reservation covers a whole 64-byte line. Several events withdraw it. A write or invalidation from another agent arrives on the snoop inputs. A context switch clears it, so that another thread on the same core cannot slip a change past it. A plain store from this core to the reserved line clears it. Any conditional store clears it, whatever its outcome. Only one reservation exists at a time, so a new reserving load replaces the old one.

Top module: `lrsc_monitor`

## Requirements
- R1: Requests use op code 0 for load, 1 for store, 2 for reserving load and 3 for conditional store. Each accepted request gives `rsp_valid` high for exactly the following cycle. Loads and reserving loads return the word selected by `req_addr[ADDR_W-1:2]` as it stood before that cycle. Stores write that word. After reset `rsp_valid` and `sc_status` are 0.
- R2: A reserving load records line `req_addr[ADDR_W-1:6]`. A conditional store to any byte of that line then succeeds and writes its data.
- R3: `sc_status` is 0 for success and 1 for failure. It is valid in the response cycle that follows a conditional store. For every other op it reads 0.
- R4: A snoop to any byte of the reserved line revokes the reservation. A snoop to a different line leaves it intact.
- R5: A conditional store fails, and leaves memory unchanged, when no reservation exists or when its line differs from the reserved line.
- R6: Every conditional store clears the reservation, whether it succeeds or fails.
- R7: Asserting `ctx_switch` clears the reservation.
- R8: A plain store from the core to the reserved line clears the reservation. A plain store to another line does not.
- R9: A second reserving load replaces the first one, so only the most recent line can be stored to conditionally.
- R10: A snoop to the target line or a context switch in the same cycle as a conditional store makes that store fail. In the same cycle as a reserving load, either one leaves no reservation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation code (see R1) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| snoop_valid | input | 1 | Write or invalidation from another agent |
| snoop_addr | input | ADDR_W | Byte address of the snooped write |
| ctx_switch | input | 1 | Context switch pulse |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata | output | DATA_W | Read data for loads |
| sc_status | output | 1 | Conditional-store result, 0 success, 1 failure |

## Verification
The hardest situation to reach is a kill event landing in exactly the same cycle as the conditional store or the reserving load it races with. From the ports this looks like an ordinary request followed by a response. The bench drives the snoop or context-switch inputs together with the request in one task call. It then proves the outcome through the status bit and through a load that reads back the word. Granule matching is swept across every word offset of every line. Snoop and plain-store kills are tried against both the reserved line and a neighbouring line.

// File: rtl/lrsc_monitor.sv
module lrsc_monitor #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              ctx_switch,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              sc_status
);
  localparam int WOFF   = $clog2(DATA_W / 8);
  localparam int LOFF   = $clog2(LINE_BYTES);
  localparam int IDX_W  = ADDR_W - WOFF;
  localparam int LINE_W = ADDR_W - LOFF;
  localparam int DEPTH  = 1 << IDX_W;

  localparam logic [1:0] OP_LD = 2'd0;
  localparam logic [1:0] OP_ST = 2'd1;
  localparam logic [1:0] OP_LR = 2'd2;
  localparam logic [1:0] OP_SC = 2'd3;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              resv_valid;
  logic [LINE_W-1:0] resv_line;

  wire [IDX_W-1:0]  widx     = req_addr[ADDR_W-1:WOFF];
  wire [LINE_W-1:0] req_line = req_addr[ADDR_W-1:LOFF];
  wire [LINE_W-1:0] snp_line = snoop_addr[ADDR_W-1:LOFF];

  logic unused_low;
  assign unused_low = ^{req_addr[LOFF-1:0], snoop_addr[LOFF-1:0]};

  wire is_st = req_valid && req_op == OP_ST;
  wire is_lr = req_valid && req_op == OP_LR;
  wire is_sc = req_valid && req_op == OP_SC;

  wire resv_hit = resv_valid && resv_line == req_line;
  wire snp_hit  = snoop_valid && resv_valid && snp_line == resv_line;
  wire snp_req  = snoop_valid && snp_line == req_line;

  wire sc_ok  = is_sc && resv_hit && !snp_req && !ctx_switch;
  wire mem_we = is_st || sc_ok;
  wire lr_set = is_lr && !snp_req && !ctx_switch;
  wire kill   = ctx_switch || snp_hit || is_sc || (is_st && resv_hit);

  always_ff @(posedge clk) begin
    if (mem_we) mem[widx] <= req_wdata;
    if (req_valid) rsp_rdata <= mem[widx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      sc_status  <= 1'b0;
      resv_valid <= 1'b0;
      resv_line  <= '0;
    end else begin
      rsp_valid <= req_valid;
      sc_status <= is_sc && !sc_ok;
      if (is_lr) begin
        resv_valid <= lr_set;
        resv_line  <= req_line;
      end else if (kill) begin
        resv_valid <= 1'b0;
      end
    end
  end

  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_sc_no_resv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sc && !resv_valid) |=> sc_status);
  p_status_non_sc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op != OP_SC) |=> !sc_status);
  p_sc_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_sc |=> !resv_valid);
  p_ctx_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_switch |=> !resv_valid);
  p_snoop_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && !is_lr) |=> !resv_valid);
  p_race_fail_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sc && (ctx_switch || snp_req)) |=> sc_status);
endmodule

// File: tb/lrsc_monitor_tb.sv
module lrsc_monitor_tb;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int NW = 1 << (AW - 2);

  logic clk = 0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          req_valid;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          snoop_valid;
  logic [AW-1:0] snoop_addr;
  logic          ctx_switch;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          sc_status;

  lrsc_monitor #(.ADDR_W(AW), .DATA_W(DW), .LINE_BYTES(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .snoop_valid(snoop_valid),
    .snoop_addr(snoop_addr), .ctx_switch(ctx_switch), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .sc_status(sc_status));

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [DW-1:0] ref_mem [NW];
  logic [DW-1:0] got_d;
  logic          got_s;
  logic          got_v;

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic op(input logic [1:0] o, input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic sv = 0, input logic [AW-1:0] sa = '0, input logic cs = 0);
    req_valid = 1; req_op = o; req_addr = a; req_wdata = d;
    snoop_valid = sv; snoop_addr = sa; ctx_switch = cs;
    @(negedge clk);
    got_d = rsp_rdata; got_s = sc_status; got_v = rsp_valid;
    req_valid = 0; snoop_valid = 0; ctx_switch = 0;
  endtask

  task automatic sc_check(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic exp_ok, input logic sv = 0,
                          input logic [AW-1:0] sa = '0, input logic cs = 0);
    op(2'd3, a, d, sv, sa, cs);
    chk({tag, " R3 status"}, {31'd0, got_s}, {31'd0, !exp_ok});
    if (exp_ok) ref_mem[a[AW-1:2]] = d;
    op(2'd0, a, '0);
    chk({tag, " R5 mem"}, got_d, ref_mem[a[AW-1:2]]);
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return 32'hA500_0000 ^ (i * 32'h0101_0103);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_op = 0; req_addr = 0; req_wdata = 0;
    snoop_valid = 0; snoop_addr = 0; ctx_switch = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset rsp_valid", {31'd0, rsp_valid}, 0);
    chk("R3 reset status", {31'd0, sc_status}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NW; i++) begin
      op(2'd1, AW'(i * 4), pat(i));
      ref_mem[i] = pat(i);
      chk("R1 store rsp_valid", {31'd0, got_v}, 1);
      chk("R3 store status", {31'd0, got_s}, 0);
    end
    @(negedge clk);
    chk("R1 idle rsp_valid", {31'd0, rsp_valid}, 0);
    for (int i = 0; i < NW; i++) begin
      op(2'd0, AW'(i * 4 + (i % 4)), '0);
      chk("R1 load data", got_d, ref_mem[i]);
    end

    for (int l = 0; l < NW / 16; l++) begin
      for (int w = 0; w < 16; w++) begin
        op(2'd2, AW'(l * 64 + ((w * 7) % 16) * 4), '0);
        chk("R1 reserving load data", got_d, ref_mem[l * 16 + (w * 7) % 16]);
        sc_check("R2 granule", AW'(l * 64 + w * 4), pat(l * 16 + w) ^ 32'hFFFF, 1);
      end
    end

    sc_check("R5 no reservation", 10'h080, 32'h1111_1111, 0);
    op(2'd2, 10'h100, '0);
    sc_check("R5 other line", 10'h140, 32'h2222_2222, 0);
    sc_check("R6 cleared after fail", 10'h100, 32'h3333_3333, 0);
    op(2'd2, 10'h100, '0);
    sc_check("R6 first succeeds", 10'h104, 32'h4444_4444, 1);
    sc_check("R6 cleared after success", 10'h104, 32'h5555_5555, 0);

    for (int b = 0; b < 64; b += 13) begin
      op(2'd2, 10'h200, '0);
      op(2'd0, 10'h000, '0, 1, AW'(10'h200 + b));
      sc_check("R4 snoop same line", 10'h208, 32'h6666_0000 + b, 0);
    end
    op(2'd2, 10'h200, '0);
    op(2'd0, 10'h000, '0, 1, 10'h240);
    sc_check("R4 snoop other line", 10'h208, 32'h7777_7777, 1);

    op(2'd2, 10'h300, '0);
    op(2'd0, 10'h000, '0, 0, '0, 1);
    sc_check("R7 context switch", 10'h300, 32'h8888_8888, 0);

    op(2'd2, 10'h300, '0);
    op(2'd1, 10'h33C, 32'h9999_9999);
    ref_mem[10'h33C >> 2] = 32'h9999_9999;
    sc_check("R8 local store same line", 10'h300, 32'hAAAA_AAAA, 0);
    op(2'd2, 10'h300, '0);
    op(2'd1, 10'h340, 32'hBBBB_BBBB);
    ref_mem[10'h340 >> 2] = 32'hBBBB_BBBB;
    sc_check("R8 local store other line", 10'h300, 32'hCCCC_CCCC, 1);

    op(2'd2, 10'h000, '0);
    op(2'd2, 10'h3C0, '0);
    sc_check("R9 newest line", 10'h3C4, 32'hDDDD_DDDD, 1);
    op(2'd2, 10'h000, '0);
    op(2'd2, 10'h3C0, '0);
    sc_check("R9 older line", 10'h004, 32'hEEEE_EEEE, 0);

    op(2'd2, 10'h0C0, '0);
    sc_check("R10 snoop with sc", 10'h0C0, 32'h0101_0101, 0, 1, 10'h0F0);
    op(2'd2, 10'h0C0, '0);
    sc_check("R10 ctx with sc", 10'h0C0, 32'h0202_0202, 0, 0, '0, 1);
    op(2'd2, 10'h0C0, '0, 1, 10'h0C8);
    sc_check("R10 snoop with lr", 10'h0C0, 32'h0303_0303, 0);
    op(2'd2, 10'h0C0, '0, 0, '0, 1);
    sc_check("R10 ctx with lr", 10'h0C0, 32'h0404_0404, 0);
    op(2'd2, 10'h0C0, '0);
    sc_check("R10 far snoop with sc", 10'h0C0, 32'h0505_0505, 1, 1, 10'h000);

    op(2'd2, 10'h010, '0);
    chk("R2 cas read", got_d, ref_mem[4]);
    sc_check("R2 cas swap", 10'h010, got_d + 1, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule